// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small processor core and decides which interrupt the core should take next. Requests come from three groups: a few top-level sources that always rank highest, a bank of peripheral lines whose rank software sets, and a single software request that ranks lowest. Each peripheral line is given one of three user levels, or left disabled, through a narrow write port. The controller compares every eligible request with the mask level the core currently runs at. It offers the winner together with its source number, its rank and a vector address.

The vector address is a relocatable table base plus the source number scaled by the table entry size. One source number can be steered to a fast path. When that source wins, the address comes from a dedicated register instead of the table. Nesting works through the mask. A handler raises the core's mask to the rank it was given, and only strictly higher ranks are offered after that. Unmaskable top sources are offered at any mask. A wake output tells the clock controller that some enabled request is pending, whatever the mask.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, irq_valid, irq_fast and wake_req are low, every peripheral line is disabled, the table base is 0 and the fast path is off.
- R2: A peripheral line's 2-bit level code selects its rank: code 0 disables the line (never offered, no wake), and codes 1, 2 and 3 give ranks 2, 3 and 4. Peripheral p has source number NTOP+p.
- R3: Among eligible requests the highest rank is offered; at equal rank the lowest source number wins.
- R4: A maskable request is offered only when its rank is strictly greater than mask_lvl. Raising mask_lvl to the rank of the running handler leaves only strictly higher ranks to preempt it.
- R5: Top sources have source numbers 0 to NTOP-1 and rank 5. Those whose NMI_MASK bit is set are offered at any mask_lvl. The others are masked when mask_lvl is 5.
- R6: The software request has rank 1 and the source number NTOP+NPER.
- R7: When no fast redirect applies, irq_vec equals the table base plus irq_num shifted left by ENTRY_SHIFT. The base is loaded through base_we.
- R8: While the fast path is enabled and the winner equals the fast source number, irq_fast is high and irq_vec equals the fast address register. For any other winner, irq_fast is low.
- R9: An edge-type peripheral (EDGE_MASK bit set) latches a rising request and stays pending after the line drops, until irq_ack while it is offered clears it. A level-type line follows its input and is not cleared by irq_ack.
- R10: wake_req is high while any enabled request is pending, including requests hidden by mask_lvl.
- R11: Request inputs and configuration writes take effect from the first clock edge after they are applied. mask_lvl acts combinationally.
- R12: If a new rising edge on an edge-type line arrives in the same cycle as the acknowledge that clears it, the line stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| top_req | input | NTOP | Top-level requests, level type |
| per_req | input | NPER | Peripheral request lines |
| swi_req | input | 1 | Software request, level type |
| mask_lvl | input | 3 | Core's current mask rank, 0 to 5 |
| cfg_we | input | 1 | Write strobe for a peripheral level code |
| cfg_sel | input | PSEL_W | Peripheral index to write |
| cfg_lvl | input | 2 | Level code, 0 disables the line |
| base_we | input | 1 | Write strobe for the vector table base |
| base_din | input | ADDR_W | New table base |
| fast_we | input | 1 | Write strobe for the fast-path registers |
| fast_en_din | input | 1 | Fast path enable |
| fast_src_din | input | IDX_W | Source number steered to the fast path |
| fast_addr_din | input | ADDR_W | Fast-path handler address |
| irq_ack | input | 1 | Core accepts the offered request |
| irq_valid | output | 1 | A request is offered |
| irq_num | output | IDX_W | Source number of the offered request |
| irq_rank | output | 3 | Rank of the offered request |
| irq_vec | output | ADDR_W | Handler address |
| irq_fast | output | 1 | Offered request uses the fast path |
| wake_req | output | 1 | Clock restart request |

## Verification
The acknowledge that clears an edge-type line and a fresh rising edge on the same line can land in one clock. The bench lets an edge line latch, drops the input for a cycle, then raises it again in the same cycle as irq_ack. It requires the source to still be offered on the next edge. A second acknowledge with the input held high, and no new edge, must then clear it. This shows that the earlier survival came from the new edge winning and not from a missed clear.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   typedef logic [2:0] rank_t;

   localparam rank_t RK_NONE = 3'd0;
   localparam rank_t RK_SW   = 3'd1;
   localparam rank_t RK_TOP  = 3'd5;

   function automatic rank_t code2rank(input logic [1:0] code);
      return (code == 2'd0) ? RK_NONE : rank_t'({1'b0, code} + 3'd1);
   endfunction
endpackage

// File: rtl/irqc_cfg.sv
module irqc_cfg #(
   parameter int NPER   = 8,
   parameter int PSEL_W = 3,
   parameter int IDX_W  = 4,
   parameter int ADDR_W = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [PSEL_W-1:0]      cfg_sel,
   input  logic [1:0]             cfg_lvl,
   input  logic                   base_we,
   input  logic [ADDR_W-1:0]      base_din,
   input  logic                   fast_we,
   input  logic                   fast_en_din,
   input  logic [IDX_W-1:0]       fast_src_din,
   input  logic [ADDR_W-1:0]      fast_addr_din,
   output logic [NPER-1:0][1:0]   per_code,
   output logic [ADDR_W-1:0]      vbase,
   output logic                   fast_en,
   output logic [IDX_W-1:0]       fast_src,
   output logic [ADDR_W-1:0]      fast_addr
);
   for (genvar g = 0; g < NPER; g++) begin : g_code
      logic [1:0] code_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            code_q <= 2'd0;
         else if (cfg_we && cfg_sel == PSEL_W'(g))
            code_q <= cfg_lvl;
      end
      assign per_code[g] = code_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         vbase <= '0;
      else if (base_we)
         vbase <= base_din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fast_en   <= 1'b0;
         fast_src  <= '0;
         fast_addr <= '0;
      end else if (fast_we) begin
         fast_en   <= fast_en_din;
         fast_src  <= fast_src_din;
         fast_addr <= fast_addr_din;
      end
   end
endmodule

// File: rtl/irqc_pend.sv
module irqc_pend #(
   parameter int              NPER      = 8,
   parameter logic [NPER-1:0] EDGE_MASK = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPER-1:0] per_req,
   input  logic [NPER-1:0] clr,
   output logic [NPER-1:0] pend
);
   for (genvar g = 0; g < NPER; g++) begin : g_src
      if (EDGE_MASK[g]) begin : g_edge
         logic req_q, rise, p_q;
         assign rise = per_req[g] & ~req_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               req_q <= 1'b0;
               p_q   <= 1'b0;
            end else begin
               req_q <= per_req[g];
               p_q   <= rise | (p_q & ~clr[g]);
            end
         end
         assign pend[g] = p_q;

         // R9 / R12: an acknowledge without a new edge empties the latch
         p_edge_ack_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[g] && !rise) |=> !pend[g]);
         p_edge_new_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[g] && rise) |=> pend[g]);
      end else begin : g_level
         logic p_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               p_q <= 1'b0;
            else
               p_q <= per_req[g];
         end
         assign pend[g] = p_q;

         p_level_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[g] && per_req[g]) |=> pend[g]);
      end
   end
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb #(
   parameter int NT    = 11,
   parameter int IDX_W = 4
) (
   input  logic                       [NT-1:0] elig,
   input  irqc_pkg::rank_t            [NT-1:0] rank,
   output logic                                valid,
   output logic [IDX_W-1:0]                    num,
   output irqc_pkg::rank_t                     best
);
   always_comb begin
      valid = 1'b0;
      num   = '0;
      best  = irqc_pkg::RK_NONE;
      for (int i = 0; i < NT; i++) begin
         if (elig[i] && rank[i] > best) begin
            valid = 1'b1;
            num   = IDX_W'(i);
            best  = rank[i];
         end
      end
   end
endmodule

// File: rtl/irqc_vec.sv
module irqc_vec #(
   parameter int IDX_W       = 4,
   parameter int ADDR_W      = 16,
   parameter int ENTRY_SHIFT = 1
) (
   input  logic              valid,
   input  logic [IDX_W-1:0]  num,
   input  logic [ADDR_W-1:0] vbase,
   input  logic              fast_en,
   input  logic [IDX_W-1:0]  fast_src,
   input  logic [ADDR_W-1:0] fast_addr,
   output logic [ADDR_W-1:0] vec,
   output logic              fast
);
   logic [ADDR_W-1:0] offs;
   assign offs = ADDR_W'(num) << ENTRY_SHIFT;
   assign fast = valid && fast_en && (num == fast_src);
   assign vec  = fast ? fast_addr : (vbase + offs);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
   parameter int              NTOP        = 2,
   parameter int              NPER        = 8,
   parameter logic [NTOP-1:0] NMI_MASK    = 2'b01,
   parameter logic [NPER-1:0] EDGE_MASK   = 8'hF0,
   parameter int              ADDR_W      = 16,
   parameter int              ENTRY_SHIFT = 1,
   localparam int             NT          = NTOP + NPER + 1,
   localparam int             IDX_W       = $clog2(NT),
   localparam int             PSEL_W      = (NPER > 1) ? $clog2(NPER) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NTOP-1:0]   top_req,
   input  logic [NPER-1:0]   per_req,
   input  logic              swi_req,
   input  logic [2:0]        mask_lvl,
   input  logic              cfg_we,
   input  logic [PSEL_W-1:0] cfg_sel,
   input  logic [1:0]        cfg_lvl,
   input  logic              base_we,
   input  logic [ADDR_W-1:0] base_din,
   input  logic              fast_we,
   input  logic              fast_en_din,
   input  logic [IDX_W-1:0]  fast_src_din,
   input  logic [ADDR_W-1:0] fast_addr_din,
   input  logic              irq_ack,
   output logic              irq_valid,
   output logic [IDX_W-1:0]  irq_num,
   output logic [2:0]        irq_rank,
   output logic [ADDR_W-1:0] irq_vec,
   output logic              irq_fast,
   output logic              wake_req
);
   import irqc_pkg::*;

   if (NTOP < 1) begin : g_bad_ntop
      $error("NTOP must be at least 1");
   end
   if (NPER < 1) begin : g_bad_nper
      $error("NPER must be at least 1");
   end
   if (ENTRY_SHIFT >= ADDR_W) begin : g_bad_shift
      $error("ENTRY_SHIFT must be below ADDR_W");
   end

   localparam int SW_IDX = NTOP + NPER;

   logic [NPER-1:0][1:0] per_code;
   logic [ADDR_W-1:0]    vbase, fast_addr;
   logic                 fast_en;
   logic [IDX_W-1:0]     fast_src;
   logic [NPER-1:0]      pend, clr;
   logic [NTOP-1:0]      top_q;
   logic                 sw_q;
   logic [NT-1:0]        elig, live;
   rank_t [NT-1:0]       rank;
   rank_t                best;

   irqc_cfg #(.NPER(NPER), .PSEL_W(PSEL_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_lvl(cfg_lvl),
      .base_we(base_we), .base_din(base_din),
      .fast_we(fast_we), .fast_en_din(fast_en_din),
      .fast_src_din(fast_src_din), .fast_addr_din(fast_addr_din),
      .per_code(per_code), .vbase(vbase),
      .fast_en(fast_en), .fast_src(fast_src), .fast_addr(fast_addr)
   );

   irqc_pend #(.NPER(NPER), .EDGE_MASK(EDGE_MASK)) u_pend (
      .clk(clk), .rst_n(rst_n), .per_req(per_req), .clr(clr), .pend(pend)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top_q <= '0;
         sw_q  <= 1'b0;
      end else begin
         top_q <= top_req;
         sw_q  <= swi_req;
      end
   end

   for (genvar g = 0; g < NTOP; g++) begin : g_top
      assign rank[g] = RK_TOP;
      assign live[g] = top_q[g];
      if (NMI_MASK[g]) begin : g_nmi
         assign elig[g] = top_q[g];
      end else begin : g_msk
         assign elig[g] = top_q[g] && (RK_TOP > mask_lvl);
      end
   end

   for (genvar g = 0; g < NPER; g++) begin : g_per
      assign rank[NTOP+g] = code2rank(per_code[g]);
      assign live[NTOP+g] = pend[g] && (rank[NTOP+g] != RK_NONE);
      assign elig[NTOP+g] = live[NTOP+g] && (rank[NTOP+g] > mask_lvl);
      assign clr[g]       = irq_ack && irq_valid && (irq_num == IDX_W'(NTOP + g));
   end

   assign rank[SW_IDX] = RK_SW;
   assign live[SW_IDX] = sw_q;
   assign elig[SW_IDX] = sw_q && (RK_SW > mask_lvl);

   irqc_arb #(.NT(NT), .IDX_W(IDX_W)) u_arb (
      .elig(elig), .rank(rank), .valid(irq_valid), .num(irq_num), .best(best)
   );
   assign irq_rank = best;

   irqc_vec #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .ENTRY_SHIFT(ENTRY_SHIFT)) u_vec (
      .valid(irq_valid), .num(irq_num), .vbase(vbase),
      .fast_en(fast_en), .fast_src(fast_src), .fast_addr(fast_addr),
      .vec(irq_vec), .fast(irq_fast)
   );

   assign wake_req = |live;

   logic nmi_win;
   always_comb begin
      nmi_win = 1'b0;
      for (int i = 0; i < NTOP; i++)
         if (NMI_MASK[i] && irq_num == IDX_W'(i)) nmi_win = 1'b1;
   end

   p_above_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> (irq_rank > mask_lvl) || nmi_win);
   p_rank_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> irq_rank != 3'd0);
   p_fast_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_fast |-> irq_valid && fast_en && irq_num == fast_src);
   p_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> wake_req);
endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  top_req = '0;
   logic [7:0]  per_req = '0;
   logic        swi_req = 1'b0;
   logic [2:0]  mask_lvl = '0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [1:0]  cfg_lvl = '0;
   logic        base_we = 1'b0;
   logic [15:0] base_din = '0;
   logic        fast_we = 1'b0;
   logic        fast_en_din = 1'b0;
   logic [3:0]  fast_src_din = '0;
   logic [15:0] fast_addr_din = '0;
   logic        irq_ack = 1'b0;
   logic        irq_valid, irq_fast, wake_req;
   logic [3:0]  irq_num;
   logic [2:0]  irq_rank;
   logic [15:0] irq_vec;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   irq_prio_ctrl u_irq_prio_ctrl (
      .clk(clk), .rst_n(rst_n), .top_req(top_req), .per_req(per_req),
      .swi_req(swi_req), .mask_lvl(mask_lvl), .cfg_we(cfg_we),
      .cfg_sel(cfg_sel), .cfg_lvl(cfg_lvl), .base_we(base_we),
      .base_din(base_din), .fast_we(fast_we), .fast_en_din(fast_en_din),
      .fast_src_din(fast_src_din), .fast_addr_din(fast_addr_din),
      .irq_ack(irq_ack), .irq_valid(irq_valid), .irq_num(irq_num),
      .irq_rank(irq_rank), .irq_vec(irq_vec), .irq_fast(irq_fast),
      .wake_req(wake_req)
   );

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic offered(input string req, input int num, input int rk);
      chk(req, irq_valid, 1);
      chk(req, irq_num, num);
      chk(req, irq_rank, rk);
   endtask

   task automatic set_lvl(input int p, input int code);
      cfg_we = 1'b1; cfg_sel = 3'(p); cfg_lvl = 2'(code);
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic quiet();
      top_req = '0; per_req = '0; swi_req = 1'b0; mask_lvl = '0; irq_ack = 1'b0;
      tick(); tick();
   endtask

   task automatic t_reset();
      chk("R1 valid", irq_valid, 0);
      chk("R1 fast", irq_fast, 0);
      chk("R1 wake", wake_req, 0);
      per_req[0] = 1'b1;
      tick();
      chk("R2 disabled line not offered", irq_valid, 0);
      chk("R2 disabled line no wake", wake_req, 0);
      quiet();
   endtask

   task automatic t_level_cfg();
      set_lvl(0, 2);
      per_req[0] = 1'b1;
      #1;
      chk("R11 not before edge", irq_valid, 0);
      tick();
      offered("R2 code2 rank3", 2, 3);
      quiet();
   endtask

   task automatic t_priority();
      set_lvl(0, 1); set_lvl(1, 3); set_lvl(2, 3);
      per_req[2:0] = 3'b111;
      tick();
      offered("R3 tie lowest number", 3, 4);
      per_req[1] = 1'b0;
      tick();
      offered("R3 next same rank", 4, 4);
      per_req[2] = 1'b0;
      tick();
      offered("R3 lower rank left", 2, 2);
      quiet();
   endtask

   task automatic t_mask();
      per_req[0] = 1'b1; per_req[2] = 1'b1;
      mask_lvl = 3'd4;
      tick();
      chk("R4 equal rank masked", irq_valid, 0);
      chk("R10 wake while masked", wake_req, 1);
      mask_lvl = 3'd3; #1;
      offered("R4 above mask", 4, 4);
      mask_lvl = 3'd4;
      top_req[1] = 1'b1;
      tick();
      offered("R4 nesting preempt", 1, 5);
      mask_lvl = 3'd5; #1;
      chk("R5 maskable top masked", irq_valid, 0);
      top_req[0] = 1'b1;
      tick();
      offered("R5 unmaskable top", 0, 5);
      quiet();
   endtask

   task automatic t_sw();
      swi_req = 1'b1;
      tick();
      offered("R6 software request", 10, 1);
      mask_lvl = 3'd1; #1;
      chk("R6 software masked", irq_valid, 0);
      quiet();
   endtask

   task automatic t_vector();
      base_we = 1'b1; base_din = 16'h1000;
      tick();
      base_we = 1'b0;
      set_lvl(3, 1);
      per_req[3] = 1'b1;
      tick();
      offered("R7 source", 5, 2);
      chk("R7 vector", irq_vec, 16'h100A);
      chk("R7 no fast", irq_fast, 0);
   endtask

   task automatic t_fast();
      fast_we = 1'b1; fast_en_din = 1'b1; fast_src_din = 4'd5; fast_addr_din = 16'hBEEF;
      tick();
      fast_we = 1'b0;
      chk("R8 fast flag", irq_fast, 1);
      chk("R8 fast address", irq_vec, 16'hBEEF);
      per_req[1] = 1'b1;
      tick();
      offered("R8 other winner", 3, 4);
      chk("R8 other not fast", irq_fast, 0);
      chk("R8 other vector", irq_vec, 16'h1006);
      quiet();
   endtask

   task automatic t_edge();
      set_lvl(4, 2);
      per_req[4] = 1'b1; tick();
      per_req[4] = 1'b0; tick();
      offered("R9 edge held after drop", 6, 3);
      irq_ack = 1'b1; tick(); irq_ack = 1'b0;
      chk("R9 edge cleared by ack", irq_valid, 0);
      per_req[0] = 1'b1; tick();
      irq_ack = 1'b1; tick(); irq_ack = 1'b0;
      offered("R9 level survives ack", 2, 2);
      per_req[0] = 1'b0; tick();
      per_req[4] = 1'b1; tick();
      per_req[4] = 1'b0; tick();
      per_req[4] = 1'b1; irq_ack = 1'b1; tick(); irq_ack = 1'b0;
      offered("R12 new edge beats ack", 6, 3);
      irq_ack = 1'b1; tick(); irq_ack = 1'b0;
      chk("R12 ack without edge clears", irq_valid, 0);
      quiet();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      tick();
      t_reset();
      t_level_cfg();
      t_priority();
      t_mask();
      t_sw();
      t_vector();
      t_fast();
      t_edge();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule